// File: doc/BRIEF.md
# ASCII Modem Command Parser

This block sits behind a serial byte receiver and turns a stream of ASCII characters into modem commands. Every command opens with the two letters `r` and `m`, followed by an opcode letter and, for some opcodes, hexadecimal arguments. A carriage return (0x0D) or a line feed (0x0A) ends a command. When a command is accepted, the parser raises a one-cycle request strobe, and for some commands it also updates a setting register.

The send command is handled differently. It carries a destination ID and a payload, both written as ASCII hex. The parser announces the destination with a start strobe. It then packs each pair of payload digits into one byte, high nibble first, with one strobe per byte. An end strobe closes the stream.

A character that does not fit the grammar sends the parser back to hunting for the `r` prefix and raises an error pulse. If a payload stream is open at that moment, the end strobe also fires so that downstream logic always sees the stream closed. All strobes and argument registers are registered: they appear in the cycle after the clock edge that accepts the deciding byte.

Top module: `rmcmd_parser`

## Requirements
- R1: While searching for a command, every byte except `r` is dropped, including a bare terminator (0x0D or 0x0A), with no strobe and no error. `r` followed by `m` opens a command.
- R2: `rmct` plus terminator pulses `tick_req`. `rmcf` plus terminator pulses `freq_req`.
- R3: `rmr` plus terminator pulses `stat_req`.
- R4: `rmv`, one hex digit and a terminator pulse `verb_set` and load the low VERB_W bits of the digit into `verb_level`. `verb_level` changes at no other time.
- R5: `rmd` plus terminator pulses `dflt_get` and leaves `dflt_id` unchanged. `rmd`, two hex digits and a terminator load `dflt_id` (first digit in bits 7:4) and pulse `dflt_set`. `dflt_id` changes at no other time.
- R6: In `rms`, the two hex digits after the opcode form the destination. The cycle after the second of these digits is accepted, `tx_start` pulses and `tx_dest` holds the destination, with the first digit in bits 7:4.
- R7: Each later pair of hex digits produces one `tx_valid` pulse, in the cycle after the pair's second digit. `tx_data[7:4]` holds the first digit of the pair. No byte appears in the cycle right after `tx_start`.
- R8: A terminator after an even number of payload digits pulses `tx_end` with no error.
- R9: Hex digits are accepted as 0-9, A-F and a-f, with equal values for both letter cases.
- R10: Any byte that breaks the grammar pulses `err` and returns the parser to prefix search. This covers a bad opcode, a non-hex argument, a missing or early terminator, and an odd payload digit count. If a payload stream is open, `tx_end` pulses in the same cycle and the partial byte is dropped. Every strobe follows an accepted input byte.
- R11: After reset, all strobes are low, `verb_level` is 0, `dflt_id` equals DFLT_ID_INIT and `tx_dest`/`tx_data` are 0.
- R12: At most one of the request strobes, `tx_start`, `tx_valid` and `err` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 8 | Received ASCII byte |
| rx_valid | input | 1 | `rx_data` is valid this cycle |
| stat_req | output | 1 | State-register request strobe |
| tick_req | output | 1 | Clock-tick value request strobe |
| freq_req | output | 1 | Clock-tick frequency request strobe |
| verb_set | output | 1 | Verbose level updated strobe |
| verb_level | output | VERB_W | Current verbose level |
| dflt_get | output | 1 | Default recipient read request strobe |
| dflt_set | output | 1 | Default recipient updated strobe |
| dflt_id | output | 8 | Current default recipient ID |
| tx_start | output | 1 | Send stream opens, `tx_dest` valid |
| tx_dest | output | 8 | Destination ID of the send stream |
| tx_valid | output | 1 | Payload byte strobe |
| tx_data | output | 8 | Payload byte |
| tx_end | output | 1 | Send stream closes |
| err | output | 1 | Grammar violation strobe |

## Verification
Every opcode is driven with its correct form to show that each one reaches only its own strobe. A send with mixed-case digits over three bytes checks both the packing order and the case folding. Noise containing no `r`, with bare terminators, shows that the prefix search really does drop input. Malformed commands each break at a different point: a wrong second prefix letter, an unknown opcode, a non-hex argument, a truncated argument, an odd payload count and a non-hex payload digit. Together they separate an error raised before a stream opens from one raised after it, where `tx_end` must pulse as well. A valid command after these errors shows that the parser recovers.

// File: rtl/rmcmd_pkg.sv
package rmcmd_pkg;

   localparam logic [7:0] CH_CR = 8'h0D;
   localparam logic [7:0] CH_LF = 8'h0A;

   typedef enum logic [3:0] {
      P_IDLE, P_M, P_OP,
      P_SID0, P_SID1, P_SHI, P_SLO,
      P_VDIG, P_VEND, P_REND,
      P_DA0, P_DA1, P_DEND,
      P_CSEL, P_CTEND, P_CFEND
   } pstate_t;

   function automatic logic is_term(input logic [7:0] c);
      return (c == CH_CR) || (c == CH_LF);
   endfunction

endpackage

// File: rtl/rmcmd_hexdec.sv
module rmcmd_hexdec #(
   parameter bit LOWER_OK = 1'b1
) (
   input  logic [7:0] ch,
   output logic       is_hex,
   output logic [3:0] nib
);
   logic digit, upper, lower;

   always_comb begin
      digit = (ch >= 8'h30) && (ch <= 8'h39);
      upper = (ch >= 8'h41) && (ch <= 8'h46);
   end

   generate
      if (LOWER_OK) begin : g_fold
         always_comb lower = (ch >= 8'h61) && (ch <= 8'h66);
      end else begin : g_strict
         always_comb lower = 1'b0;
      end
   endgenerate

   always_comb begin
      is_hex = digit | upper | lower;
      nib    = ch[3:0] + ((upper | lower) ? 4'd9 : 4'd0);
   end
endmodule

// File: rtl/rmcmd_nibble_acc.sv
module rmcmd_nibble_acc #(
   parameter int ACC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift,
   input  logic [3:0]       nib,
   output logic [ACC_W-1:0] acc
);
   generate
      if (ACC_W < 8 || (ACC_W % 4) != 0) begin : g_bad_width
         $error("rmcmd_nibble_acc: ACC_W must be a multiple of 4, at least 8");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc <= '0;
      else if (shift) acc <= {acc[ACC_W-5:0], nib};
   end
endmodule

// File: rtl/rmcmd_parser.sv
module rmcmd_parser
   import rmcmd_pkg::*;
#(
   parameter int         VERB_W       = 4,
   parameter bit         LOWER_OK     = 1'b1,
   parameter logic [7:0] DFLT_ID_INIT = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        rx_data,
   input  logic              rx_valid,
   output logic              stat_req,
   output logic              tick_req,
   output logic              freq_req,
   output logic              verb_set,
   output logic [VERB_W-1:0] verb_level,
   output logic              dflt_get,
   output logic              dflt_set,
   output logic [7:0]        dflt_id,
   output logic              tx_start,
   output logic [7:0]        tx_dest,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              tx_end,
   output logic              err
);
   localparam int ACC_W = 8;

   generate
      if (VERB_W < 1 || VERB_W > 4) begin : g_bad_verb
         $error("rmcmd_parser: VERB_W must lie in 1..4");
      end
   endgenerate

   pstate_t          st, nxt;
   logic             hex_ok, term, shift;
   logic [3:0]       nib;
   logic [ACC_W-1:0] acc;
   logic [7:0]       pair;
   logic n_stat, n_tick, n_freq, n_verb, n_dget, n_dset;
   logic n_start, n_valid, n_end, n_err;

   rmcmd_hexdec #(.LOWER_OK(LOWER_OK)) u_hex (
      .ch(rx_data), .is_hex(hex_ok), .nib(nib)
   );

   rmcmd_nibble_acc #(.ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .shift(shift), .nib(nib), .acc(acc)
   );

   always_comb begin
      term    = is_term(rx_data);
      pair    = {acc[3:0], nib};
      nxt     = st;
      shift   = 1'b0;
      n_stat  = 1'b0; n_tick  = 1'b0; n_freq  = 1'b0; n_verb = 1'b0;
      n_dget  = 1'b0; n_dset  = 1'b0; n_start = 1'b0;
      n_valid = 1'b0; n_end   = 1'b0; n_err   = 1'b0;
      if (rx_valid) begin
         case (st)
            P_IDLE: if (rx_data == "r") nxt = P_M;
            P_M:    if (rx_data == "m") nxt = P_OP; else n_err = 1'b1;
            P_OP:
               case (rx_data)
                  "s":     nxt = P_SID0;
                  "v":     nxt = P_VDIG;
                  "r":     nxt = P_REND;
                  "d":     nxt = P_DA0;
                  "c":     nxt = P_CSEL;
                  default: n_err = 1'b1;
               endcase
            P_SID0:
               if (hex_ok) begin shift = 1'b1; nxt = P_SID1; end
               else n_err = 1'b1;
            P_SID1:
               if (hex_ok) begin shift = 1'b1; n_start = 1'b1; nxt = P_SHI; end
               else n_err = 1'b1;
            P_SHI:
               if (hex_ok) begin shift = 1'b1; nxt = P_SLO; end
               else if (term) begin n_end = 1'b1; nxt = P_IDLE; end
               else begin n_err = 1'b1; n_end = 1'b1; end
            P_SLO:
               if (hex_ok) begin shift = 1'b1; n_valid = 1'b1; nxt = P_SHI; end
               else begin n_err = 1'b1; n_end = 1'b1; end
            P_VDIG:
               if (hex_ok) begin shift = 1'b1; nxt = P_VEND; end
               else n_err = 1'b1;
            P_VEND: if (term) begin n_verb = 1'b1; nxt = P_IDLE; end else n_err = 1'b1;
            P_REND: if (term) begin n_stat = 1'b1; nxt = P_IDLE; end else n_err = 1'b1;
            P_DA0:
               if (term) begin n_dget = 1'b1; nxt = P_IDLE; end
               else if (hex_ok) begin shift = 1'b1; nxt = P_DA1; end
               else n_err = 1'b1;
            P_DA1:
               if (hex_ok) begin shift = 1'b1; nxt = P_DEND; end
               else n_err = 1'b1;
            P_DEND: if (term) begin n_dset = 1'b1; nxt = P_IDLE; end else n_err = 1'b1;
            P_CSEL:
               if (rx_data == "t")      nxt = P_CTEND;
               else if (rx_data == "f") nxt = P_CFEND;
               else                     n_err = 1'b1;
            P_CTEND: if (term) begin n_tick = 1'b1; nxt = P_IDLE; end else n_err = 1'b1;
            P_CFEND: if (term) begin n_freq = 1'b1; nxt = P_IDLE; end else n_err = 1'b1;
            default: nxt = P_IDLE;
         endcase
         if (n_err) nxt = P_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= P_IDLE;
         stat_req   <= 1'b0; tick_req <= 1'b0; freq_req <= 1'b0;
         verb_set   <= 1'b0; dflt_get <= 1'b0; dflt_set <= 1'b0;
         tx_start   <= 1'b0; tx_valid <= 1'b0; tx_end   <= 1'b0; err <= 1'b0;
         verb_level <= '0;
         dflt_id    <= DFLT_ID_INIT;
         tx_dest    <= '0;
         tx_data    <= '0;
      end else begin
         st       <= nxt;
         stat_req <= n_stat; tick_req <= n_tick; freq_req <= n_freq;
         verb_set <= n_verb; dflt_get <= n_dget; dflt_set <= n_dset;
         tx_start <= n_start; tx_valid <= n_valid; tx_end <= n_end; err <= n_err;
         if (n_verb)  verb_level <= acc[VERB_W-1:0];
         if (n_dset)  dflt_id    <= acc;
         if (n_start) tx_dest    <= pair;
         if (n_valid) tx_data    <= pair;
      end
   end

   // R12: strobes are mutually exclusive
   assert_one_action_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stat_req, tick_req, freq_req, verb_set, dflt_get, dflt_set,
                tx_start, tx_valid, err}));

   // R5: default ID moves only together with its update strobe
   assert_dflt_only_on_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dflt_id != $past(dflt_id)) |-> dflt_set);

   // R4: verbose level moves only together with its update strobe
   assert_verb_only_on_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (verb_level != $past(verb_level)) |-> verb_set);

   // R10: every strobe is caused by an accepted byte
   assert_strobe_needs_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_req || tick_req || freq_req || verb_set || dflt_get || dflt_set ||
       tx_start || tx_valid || tx_end || err) |-> $past(rx_valid));

   // R7: a payload byte needs two digits after the stream opens
   assert_no_byte_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_valid);
endmodule

// File: tb/rmcmd_parser_test.sv
module rmcmd_parser_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic       rx_valid = 1'b0;
   logic       stat_req, tick_req, freq_req, verb_set, dflt_get, dflt_set;
   logic [3:0] verb_level;
   logic [7:0] dflt_id, tx_dest, tx_data;
   logic       tx_start, tx_valid, tx_end, err;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   int n_stat = 0, n_tick = 0, n_freq = 0, n_verb = 0, n_dget = 0, n_dset = 0;
   int n_start = 0, n_end = 0, n_err = 0, n_bytes = 0;
   logic [7:0] last_dest = 8'h00;
   logic [7:0] byte_log [0:63];

   rmcmd_parser #(.VERB_W(4), .LOWER_OK(1'b1), .DFLT_ID_INIT(8'h01)) uut (
      .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
      .stat_req(stat_req), .tick_req(tick_req), .freq_req(freq_req),
      .verb_set(verb_set), .verb_level(verb_level),
      .dflt_get(dflt_get), .dflt_set(dflt_set), .dflt_id(dflt_id),
      .tx_start(tx_start), .tx_dest(tx_dest), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_end(tx_end), .err(err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      if (rst_n) begin
         if (stat_req) n_stat++;
         if (tick_req) n_tick++;
         if (freq_req) n_freq++;
         if (verb_set) n_verb++;
         if (dflt_get) n_dget++;
         if (dflt_set) n_dset++;
         if (tx_end)   n_end++;
         if (err)      n_err++;
         if (tx_start) begin n_start++; last_dest = tx_dest; end
         if (tx_valid) begin
            if (n_bytes < 64) byte_log[n_bytes] = tx_data;
            n_bytes++;
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b);
      rx_data  = b;
      rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic run(input string s, input logic [7:0] term);
      for (int i = 0; i < s.len(); i++) send_byte(s[i]);
      if (term != 8'h00) send_byte(term);
      repeat (3) @(negedge clk);
   endtask

   int b_stat, b_tick, b_freq, b_verb, b_dget, b_dset, b_start, b_end, b_err, b_bytes;

   task automatic snap();
      b_stat = n_stat; b_tick = n_tick; b_freq = n_freq; b_verb = n_verb;
      b_dget = n_dget; b_dset = n_dset; b_start = n_start; b_end = n_end;
      b_err = n_err; b_bytes = n_bytes;
   endtask

   task automatic t_reset();
      check("R11 strobes", {stat_req, tick_req, freq_req, verb_set, dflt_get,
                            dflt_set, tx_start, tx_valid, tx_end, err}, 0);
      check("R11 verb_level", verb_level, 0);
      check("R11 dflt_id", dflt_id, 8'h01);
      check("R11 tx_dest", tx_dest, 0);
      check("R11 tx_data", tx_data, 0);
   endtask

   task automatic t_clock();
      snap(); run("rmct", 8'h0D);
      check("R2 tick", n_tick - b_tick, 1);
      check("R2 no freq", n_freq - b_freq, 0);
      snap(); run("rmcf", 8'h0A);
      check("R2 freq", n_freq - b_freq, 1);
      check("R2 no tick", n_tick - b_tick, 0);
      check("R2 no err", n_err - b_err, 0);
   endtask

   task automatic t_stat();
      snap(); run("rmr", 8'h0D);
      check("R3 stat", n_stat - b_stat, 1);
      check("R3 no err", n_err - b_err, 0);
   endtask

   task automatic t_verb();
      snap(); run("rmv7", 8'h0D);
      check("R4 verb strobe", n_verb - b_verb, 1);
      check("R4 verb level 7", verb_level, 7);
      snap(); run("rmvb", 8'h0A);
      check("R4 verb level b", verb_level, 4'hB);
      snap(); run("rmvx", 8'h0D);
      check("R10 verb bad digit err", n_err - b_err, 1);
      check("R4 verb unchanged", verb_level, 4'hB);
      check("R4 no verb strobe", n_verb - b_verb, 0);
   endtask

   task automatic t_dflt();
      snap(); run("rmd", 8'h0D);
      check("R5 get strobe", n_dget - b_dget, 1);
      check("R5 get keeps id", dflt_id, 8'h01);
      snap(); run("rmd3a", 8'h0D);
      check("R5 set strobe", n_dset - b_dset, 1);
      check("R9 R5 set id lower case", dflt_id, 8'h3A);
      snap(); run("rmd5", 8'h0D);
      check("R10 short arg err", n_err - b_err, 1);
      check("R5 short arg keeps id", dflt_id, 8'h3A);
   endtask

   task automatic t_send();
      snap(); run("rmsAB12cDfF", 8'h0D);
      check("R6 start", n_start - b_start, 1);
      check("R6 dest", last_dest, 8'hAB);
      check("R7 byte count", n_bytes - b_bytes, 3);
      check("R7 byte0", byte_log[b_bytes], 8'h12);
      check("R9 byte1 mixed case", byte_log[b_bytes+1], 8'hCD);
      check("R9 byte2 mixed case", byte_log[b_bytes+2], 8'hFF);
      check("R8 end", n_end - b_end, 1);
      check("R8 no err", n_err - b_err, 0);
   endtask

   task automatic t_noise();
      snap(); run("xyz", 8'h0D);
      run("", 8'h0A);
      check("R1 noise no err", n_err - b_err, 0);
      check("R1 noise no strobes", (n_stat - b_stat) + (n_tick - b_tick) +
            (n_start - b_start) + (n_dget - b_dget), 0);
      snap(); run("rx", 8'h0D);
      check("R1 R10 bad prefix err", n_err - b_err, 1);
   endtask

   task automatic t_bad_op();
      snap(); run("rmz", 8'h0D);
      check("R10 bad opcode err", n_err - b_err, 1);
      check("R10 bad opcode no end", n_end - b_end, 0);
   endtask

   task automatic t_odd();
      snap(); run("rmsAB123", 8'h0D);
      check("R10 odd bytes", n_bytes - b_bytes, 1);
      check("R10 odd byte value", byte_log[b_bytes], 8'h12);
      check("R10 odd err", n_err - b_err, 1);
      check("R10 odd end", n_end - b_end, 1);
   endtask

   task automatic t_bad_payload();
      snap(); run("rmsA112G", 8'h0D);
      check("R10 payload bytes", n_bytes - b_bytes, 1);
      check("R10 payload err", n_err - b_err, 1);
      check("R10 payload end", n_end - b_end, 1);
      snap(); run("rmsQ", 8'h0D);
      check("R10 bad id err", n_err - b_err, 1);
      check("R10 bad id no start", n_start - b_start, 0);
      check("R10 bad id no end", n_end - b_end, 0);
   endtask

   task automatic t_recover();
      snap(); run("rmct", 8'h0A);
      check("R10 recovery tick", n_tick - b_tick, 1);
      check("R10 recovery no err", n_err - b_err, 0);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 50000 && !done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_clock();
      t_stat();
      t_verb();
      t_dflt();
      t_send();
      t_noise();
      t_bad_op();
      t_odd();
      t_bad_payload();
      t_recover();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule